// File: doc/BRIEF.md
# Grouped Double-Buffered Compare Latch Bank

This block holds the compare values for a seven-channel timer. Software writes a compare register per channel. The comparator never looks at that register. It looks at a shadow latch, and the register value moves into the latch only on a selected load event. Each channel has a 2-bit load-event code. The code picks one of four events: the write itself, the count reaching zero, a zero or top-of-count event that depends on the counting mode, or the count reaching the channel's own latched value.

A global 2-bit gang code can tie channels into groups. In a group, one controlling channel's load code decides when every member latch takes its own register value, and all members load on the same clock edge. The block also outputs one equality flag per channel, which compares the timer count with that channel's latch. The counter and the waveform logic sit outside this block.

Top module: `cmp_shadow_bank`

## Requirements
- R1: After reset every register and latch holds zero. Each equality flag is then high exactly when the count input is zero.
- R2: A write with `wr_en` high and `wr_ch` naming a channel updates that channel's register. Under load code 0 (on write), the latch of a self-controlled channel takes the written data on the same clock edge.
- R3: Load code 1 (at zero) loads the latch on an edge where the count is zero. It does not load while the count is nonzero.
- R4: With `cnt_updown` low, load code 2 (zero or top) loads only when the count is zero. A count equal to the channel-0 latch does not load.
- R5: With `cnt_updown` high, load code 2 loads when the count is zero. It also loads when the count equals the channel-0 latch while `cnt_dir_up` is high. An equal count while counting down does not load.
- R6: Load code 3 (at own value) loads when the count equals the controlling channel's current latch value.
- R7: Gang code 0 makes every channel its own controller, so a load on one channel leaves all other latches unchanged.
- R8: Gang code 1 forms pairs 1+2, 3+4 and 5+6, controlled by channels 1, 3 and 5. Channel 0 stays on its own.
- R9: Gang code 2 forms groups 1+2+3 (controlled by channel 1) and 4+5+6 (controlled by channel 4). Channel 0 stays on its own.
- R10: Gang code 3 forms one group of channels 0 to 6, controlled by channel 1.
- R11: The load code of a channel that is not a group controller has no effect on any latch.
- R12: All members of a group load on the same edge, each from its own register. A member written on that edge takes the new data.
- R13: The equality flags compare the count with the latch, never with the register.
- R14: When the controller's code is 0, a write to the controller loads every latch of its group. A write to a non-controller member loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 3 | Channel index of the write; values 7 and above are ignored |
| wr_data | input | CNT_W | Write data |
| ld_sel | input | 2*NUM_CH | Load-event code per channel, channel i in bits [2i+1:2i] |
| gang_sel | input | 2 | Channel grouping code |
| cnt | input | CNT_W | Current timer count |
| cnt_dir_up | input | 1 | High while the counter counts upward |
| cnt_updown | input | 1 | High when the counter runs in up/down mode |
| lat_o | output | NUM_CH*CNT_W | Latch values, channel i in bits [i*CNT_W +: CNT_W] |
| eq_o | output | NUM_CH | Per-channel equality of count and latch |

## Verification
The embedded properties check on every cycle the following:
- a register takes each write;
- a latch without a load enable holds its value;
- a loaded latch takes its register or the simultaneous write;
- an ungrouped on-write channel follows its writes;
- a channel-0 at-zero latch stays still while the count is nonzero;
- in the all-channel group the load enables agree.

Only the directed scenarios can show the rest:
- the exact group membership under each gang code;
- whether a non-controller's code is ignored;
- the direction qualification of the top-of-count event;
- the same-edge ordering when a write and an event coincide.

// File: rtl/cmp_shadow_pkg.sv
`timescale 1ns/1ps
package cmp_shadow_pkg;

   localparam int unsigned CH_COUNT = 7;
   localparam int unsigned CH_IDX_W = 3;

   typedef enum logic [1:0] {
      LD_ON_WRITE    = 2'd0,
      LD_AT_ZERO     = 2'd1,
      LD_ZERO_OR_TOP = 2'd2,
      LD_AT_OWN      = 2'd3
   } ld_evt_e;

   typedef enum logic [1:0] {
      GANG_NONE    = 2'd0,
      GANG_PAIRS   = 2'd1,
      GANG_TRIPLES = 2'd2,
      GANG_ALL     = 2'd3
   } gang_e;

   // controlling channel of channel ch under a grouping code
   function automatic logic [CH_IDX_W-1:0] ctrl_of(input logic [CH_IDX_W-1:0] ch,
                                                   input gang_e g);
      logic [CH_IDX_W-1:0] c;
      case (g)
         GANG_NONE:    c = ch;
         GANG_PAIRS:   c = (ch == '0) ? '0 : (ch[0] ? ch : CH_IDX_W'(ch - 1'b1));
         GANG_TRIPLES: c = (ch == '0) ? '0 : ((ch <= CH_IDX_W'(3)) ? CH_IDX_W'(1) : CH_IDX_W'(4));
         GANG_ALL:     c = CH_IDX_W'(1);
         default:      c = ch;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/cmp_evt_gen.sv
`timescale 1ns/1ps
module cmp_evt_gen
   import cmp_shadow_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  ld_evt_e           ld_code,
   input  logic              wr_hit,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  own_lat,
   input  logic [CNT_W-1:0]  top_lat,
   input  logic              updown,
   input  logic              dir_up,
   output logic              fire
);
   logic at_zero;
   logic at_top;

   assign at_zero = (cnt == '0);
   assign at_top  = updown && dir_up && (cnt == top_lat);

   always_comb begin
      case (ld_code)
         LD_ON_WRITE:    fire = wr_hit;
         LD_AT_ZERO:     fire = at_zero;
         LD_ZERO_OR_TOP: fire = at_zero || at_top;
         LD_AT_OWN:      fire = (cnt == own_lat);
         default:        fire = 1'b0;
      endcase
   end
endmodule

// File: rtl/cmp_gang_map.sv
`timescale 1ns/1ps
module cmp_gang_map
   import cmp_shadow_pkg::*;
#(
   parameter int unsigned NUM_CH = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  gang_e             gang,
   input  logic [NUM_CH-1:0] fire,
   output logic [NUM_CH-1:0] load
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_map
      logic [CH_IDX_W-1:0] ctl;
      assign ctl     = ctrl_of(CH_IDX_W'(i), gang);
      assign load[i] = fire[ctl];
   end

   // R10: with one global group the enables move together
   p_all_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gang == GANG_ALL) |-> (load == '0 || load == '1));
endmodule

// File: rtl/cmp_slot.sv
`timescale 1ns/1ps
module cmp_slot #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             load,
   output logic [CNT_W-1:0] lat
);
   logic [CNT_W-1:0] cmp_reg;
   logic [CNT_W-1:0] src;

   assign src = wr_hit ? wr_data : cmp_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_reg <= '0;
         lat     <= '0;
      end else begin
         if (wr_hit) cmp_reg <= wr_data;
         if (load)   lat     <= src;
      end
   end

   p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (cmp_reg == $past(wr_data)));
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(lat));
   p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (load && wr_hit) |=> (lat == $past(wr_data)));
endmodule

// File: rtl/cmp_shadow_bank.sv
`timescale 1ns/1ps
module cmp_shadow_bank
   import cmp_shadow_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NUM_CH = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [$clog2(NUM_CH)-1:0] wr_ch,
   input  logic [CNT_W-1:0]          wr_data,
   input  logic [2*NUM_CH-1:0]       ld_sel,
   input  logic [1:0]                gang_sel,
   input  logic [CNT_W-1:0]          cnt,
   input  logic                      cnt_dir_up,
   input  logic                      cnt_updown,
   output logic [NUM_CH*CNT_W-1:0]   lat_o,
   output logic [NUM_CH-1:0]         eq_o
);
   localparam int unsigned CH_W = $clog2(NUM_CH);

   if (NUM_CH != CH_COUNT) begin : g_bad_ch
      $error("cmp_shadow_bank: grouping needs exactly seven channels");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("cmp_shadow_bank: CNT_W must be at least 2");
   end

   gang_e             gang;
   logic [CNT_W-1:0]  lat [NUM_CH];
   logic [NUM_CH-1:0] fire;
   logic [NUM_CH-1:0] load;
   logic [NUM_CH-1:0] hit;

   assign gang = gang_e'(gang_sel);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign hit[i] = wr_en && (wr_ch == CH_W'(i));

      cmp_evt_gen #(.CNT_W(CNT_W)) u_evt (
         .ld_code (ld_evt_e'(ld_sel[2*i +: 2])),
         .wr_hit  (hit[i]),
         .cnt     (cnt),
         .own_lat (lat[i]),
         .top_lat (lat[0]),
         .updown  (cnt_updown),
         .dir_up  (cnt_dir_up),
         .fire    (fire[i])
      );

      cmp_slot #(.CNT_W(CNT_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_hit  (hit[i]),
         .wr_data (wr_data),
         .load    (load[i]),
         .lat     (lat[i])
      );

      assign lat_o[i*CNT_W +: CNT_W] = lat[i];
      assign eq_o[i] = (cnt == lat[i]);

      if (i != 0) begin : g_imm_chk
         // R2: ungrouped on-write channel follows its writes
         p_imm_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (gang == GANG_NONE && ld_sel[2*i +: 2] == 2'd0 && hit[i])
            |=> (lat_o[i*CNT_W +: CNT_W] == $past(wr_data)));
      end
   end

   cmp_gang_map #(.NUM_CH(NUM_CH)) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .gang  (gang),
      .fire  (fire),
      .load  (load)
   );

   // R3: channel 0 at-zero latch does not move while count is nonzero
   p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gang != GANG_ALL && ld_sel[1:0] == 2'd1 && cnt != '0)
      |=> $stable(lat_o[CNT_W-1:0]));
endmodule

// File: tb/tb_cmp_shadow_bank.sv
`timescale 1ns/1ps
module tb_cmp_shadow_bank;
   localparam int CW = 16;
   localparam int NC = 7;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en;
   logic [2:0]    wr_ch;
   logic [CW-1:0] wr_data;
   logic [2*NC-1:0] ld_sel;
   logic [1:0]    gang_sel;
   logic [CW-1:0] cnt;
   logic          cnt_dir_up;
   logic          cnt_updown;
   logic [NC*CW-1:0] lat_o;
   logic [NC-1:0] eq_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   cmp_shadow_bank #(.CNT_W(CW), .NUM_CH(NC)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
      .ld_sel(ld_sel), .gang_sel(gang_sel), .cnt(cnt), .cnt_dir_up(cnt_dir_up),
      .cnt_updown(cnt_updown), .lat_o(lat_o), .eq_o(eq_o)
   );

   function automatic logic [CW-1:0] lat_of(int ch);
      return lat_o[ch*CW +: CW];
   endfunction

   task automatic chk(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(int ch, logic [CW-1:0] d);
      wr_en = 1'b1; wr_ch = 3'(ch); wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic set_ld(int ch, logic [1:0] v);
      ld_sel[2*ch +: 2] = v;
   endtask

   task automatic t_reset();
      for (int i = 0; i < NC; i++) chk("R1 latch zero", lat_of(i), '0);
      chk("R1 eq low at nonzero count", CW'(eq_o), '0);
      cnt = 0; #1;
      chk("R1 eq high at zero count", CW'(eq_o), CW'(7'h7F));
      cnt = 5; #1;
   endtask

   task automatic t_immediate();
      wr(3, 16'h1234);
      chk("R2 on-write load", lat_of(3), 16'h1234);
      chk("R7 neighbour untouched", lat_of(2), 16'h0000);
   endtask

   task automatic t_at_zero();
      set_ld(4, 2'd1);
      wr(4, 16'h0005);
      chk("R3 no load at nonzero count", lat_of(4), 16'h0000);
      chk("R13 eq uses latch", CW'(eq_o[4]), 16'h0);
      cnt = 0; tick();
      chk("R3 load at zero", lat_of(4), 16'h0005);
      cnt = 5; #1;
      chk("R13 eq after load", CW'(eq_o[4]), 16'h1);
      set_ld(4, 2'd0);
   endtask

   task automatic t_zero_or_top();
      wr(0, 16'h0040);
      chk("R2 channel 0 set", lat_of(0), 16'h0040);
      set_ld(2, 2'd2);
      cnt = 16'h10;
      wr(2, 16'h0077);
      chk("R4 no load on write", lat_of(2), 16'h0000);
      cnt_updown = 0; cnt = 16'h40; tick();
      chk("R4 top ignored outside up/down", lat_of(2), 16'h0000);
      cnt = 0; tick();
      chk("R4 load at zero", lat_of(2), 16'h0077);
      cnt = 16'h10; wr(2, 16'h0088);
      cnt_updown = 1; cnt_dir_up = 1; cnt = 16'h40; tick();
      chk("R5 load at top counting up", lat_of(2), 16'h0088);
      cnt = 16'h10; wr(2, 16'h0099);
      cnt_dir_up = 0; cnt = 16'h40; tick();
      chk("R5 no load at top counting down", lat_of(2), 16'h0088);
      cnt = 0; tick();
      chk("R5 load at zero in up/down", lat_of(2), 16'h0099);
      set_ld(2, 2'd0); cnt_updown = 0; cnt_dir_up = 1; cnt = 16'h10;
   endtask

   task automatic t_at_own();
      set_ld(5, 2'd3);
      cnt = 16'h20;
      wr(5, 16'h0030);
      chk("R6 no load off own value", lat_of(5), 16'h0000);
      cnt = 0; tick();
      chk("R6 load at own value", lat_of(5), 16'h0030);
      cnt = 16'h20; wr(5, 16'h0050);
      chk("R6 holds until own value", lat_of(5), 16'h0030);
      cnt = 16'h30; tick();
      chk("R6 load at new own value", lat_of(5), 16'h0050);
      set_ld(5, 2'd0); cnt = 16'h100;
   endtask

   task automatic t_pairs();
      gang_sel = 2'd1; set_ld(3, 2'd1); set_ld(4, 2'd3);
      wr(3, 16'h00B3);
      chk("R8 controller code governs", lat_of(3), 16'h1234);
      wr(4, 16'h00B4);
      chk("R11 member write no load", lat_of(4), 16'h0005);
      cnt = 16'h0005; tick();
      chk("R11 member code ignored", lat_of(4), 16'h0005);
      cnt = 0;
      wr(4, 16'h00C4);
      chk("R8 pair controller loads", lat_of(3), 16'h00B3);
      chk("R12 member same edge new data", lat_of(4), 16'h00C4);
      chk("R8 other pair untouched", lat_of(5), 16'h0050);
      cnt = 16'h100;
      wr(2, 16'h00C2);
      chk("R11 member on-write ignored", lat_of(2), 16'h0099);
      wr(1, 16'h00C1);
      chk("R14 controller write loads itself", lat_of(1), 16'h00C1);
      chk("R14 controller write loads member", lat_of(2), 16'h00C2);
   endtask

   task automatic t_triples();
      set_ld(3, 2'd0); set_ld(4, 2'd1); gang_sel = 2'd2; cnt = 16'h100;
      wr(5, 16'h00D5);
      wr(6, 16'h00D6);
      chk("R9 member write no load", lat_of(5), 16'h0050);
      chk("R9 member write no load", lat_of(6), 16'h0000);
      wr(4, 16'h00D4);
      chk("R9 controller waits for zero", lat_of(4), 16'h00C4);
      cnt = 0; tick();
      chk("R9 group 4 loads", lat_of(4), 16'h00D4);
      chk("R9 group 5 loads", lat_of(5), 16'h00D5);
      chk("R9 group 6 loads", lat_of(6), 16'h00D6);
      chk("R9 other triple holds", lat_of(3), 16'h00B3);
      chk("R9 channel 0 independent", lat_of(0), 16'h0040);
      cnt = 16'h100; set_ld(4, 2'd0);
   endtask

   task automatic t_all();
      gang_sel = 2'd3; set_ld(1, 2'd3); set_ld(0, 2'd1); cnt = 16'h100;
      wr(0, 16'h00E0);
      chk("R10 channel 0 write no load", lat_of(0), 16'h0040);
      wr(6, 16'h00E6);
      wr(1, 16'h00E1);
      chk("R10 controller code 3 no write load", lat_of(1), 16'h00C1);
      cnt = 0; tick();
      chk("R11 channel 0 code ignored", lat_of(0), 16'h0040);
      cnt = 16'h00C1; tick();
      chk("R10 all load ch0", lat_of(0), 16'h00E0);
      chk("R10 all load ch1", lat_of(1), 16'h00E1);
      chk("R10 all load ch2", lat_of(2), 16'h00C2);
      chk("R10 all load ch4", lat_of(4), 16'h00D4);
      chk("R10 all load ch6", lat_of(6), 16'h00E6);
   endtask

   initial begin
      #(4 * 100000);
      n_bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_data = '0; ld_sel = '0;
      gang_sel = 2'd0; cnt = 16'd5; cnt_dir_up = 1'b1; cnt_updown = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      t_immediate();
      t_at_zero();
      t_zero_or_top();
      t_at_own();
      t_pairs();
      t_triples();
      t_all();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule